// File: doc/BRIEF.md
# Daisy-Chain Interrupt Requester Node

This block is the peripheral-side interrupt logic for one device on a prioritised request chain. Three lines connect all devices in series: a request line (IRQ) that flows toward the CPU, an acknowledge line (IAK) that flows away from it, and an active-low service-end pulse (ISE) that also flows away from it. A device's priority comes only from its position. The node nearest the CPU wins. A node with no business of its own forwards all three lines unchanged.

When the local device raises its request, the node breaks the chain first. Devices further out can then no longer reach the CPU or see acknowledges. One clock later the node raises IRQ. While IAK is active, the node places its handler address (set by a static input, in the manner of switches) on a shared data bus. When IAK goes away, it releases the bus and drops IRQ. The chain stays broken for the whole life of the handler. It is rejoined only after the rising edge of the service-end pulse, and that pulse is never passed further out. Any lower-priority request that was held back then reaches the CPU.

Several instances are cascaded by wiring one node's outward-facing IRQ input and IAK/ISE outputs to the next node's matching pins.

Top module: `irq_chain_node`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the node returns to idle with the chain closed, no request of its own, no record of downstream ownership, `bus_oe` = 0 and `bus_data` = 0.
- R2: With the chain closed, `irq_out` equals `irq_in`, `iak_out` equals `iak_in` and `ise_n_out` equals `ise_n_in` in the same cycle, with no register in between.
- R3: A local request is taken when `dev_req` = 1 at a rising edge while the node is idle, `iak_in` = 0 and no downstream owner is recorded. From that edge the chain is open: `iak_out` = 0, `ise_n_out` = 1 and `irq_out` no longer follows `irq_in`. `irq_out` rises at the next rising edge, so the chain is broken one full cycle before IRQ is raised.
- R4: From the moment the chain opens until the acknowledge ends, `bus_oe` follows `iak_in` in the same cycle. `bus_data` equals `handler_addr` whenever `bus_oe` = 1 and is all zeros otherwise.
- R5: Once the acknowledge has been seen, the first rising edge that samples `iak_in` = 0 clears `irq_out` to 0. The chain stays open, which puts the node in service.
- R6: In service, a low pulse on `ise_n_in` never reaches `ise_n_out`. The pulse must span a falling clock edge. The chain closes at the second rising edge after the pulse returns high, and not before.
- R7: If `iak_in` = 1 at a rising edge while the chain is closed, a downstream node is recorded as owner. Local requests are then ignored and the chain stays closed until a service-end pulse is seen with the chain closed. The node may open the chain at the rising edge that follows the one that clears that record.
- R8: A downstream request that is pending but not yet acknowledged (`irq_in` = 1, `iak_in` = 0) does not hold back a local request. The local request breaks the chain and takes the CPU.
- R9: With three cascaded nodes requesting in the same cycle, the CPU receives the three handler addresses in chain order, one per acknowledge. Exactly one node drives the bus during each acknowledge, and IRQ is idle after the third handler ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge and the service-end line is sampled on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 1 | Local device asks for service (level, active high) |
| handler_addr | input | ADDR_W | Static handler address that this node presents on acknowledge |
| irq_in | input | 1 | Request from the next node further from the CPU |
| irq_out | output | 1 | Request toward the CPU or the previous node |
| iak_in | input | 1 | Acknowledge from the CPU side |
| iak_out | output | 1 | Acknowledge passed to the next node further out |
| ise_n_in | input | 1 | Active-low service-end pulse from the CPU side |
| ise_n_out | output | 1 | Service-end pulse passed further out |
| bus_data | output | ADDR_W | Handler address while enabled, zeros otherwise |
| bus_oe | output | 1 | Tri-state enable for the shared data bus |

## Verification
If the node's state is wrong, it shows on the chain pins within one cycle. A node that opens the chain too late lets `iak_out` leak an acknowledge outward while `bus_oe` is also high. A node that opens too early shows `irq_out` cut off from `irq_in` one cycle ahead of time. A service flag that clears too soon lets the service-end pulse through, or lets a far request reach `irq_out` before the second edge after the pulse. One that never clears keeps `irq_out` stuck low for good. A downstream-owner record that is lost or wrong shows as the chain opening on a blocked local request, and in the cascade as handler addresses read out of chain order or as two enables active in the same acknowledge.

// File: rtl/irq_chain_pkg.sv
`timescale 1ns/1ps
// Package: irq_chain_pkg
// Shared state encoding for the chain node. The order of the
// values has no meaning beyond readability; every decode is by name.
package irq_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // chain closed, lines forwarded
        ST_OPEN  = 3'd1,  // chain broken, IRQ not yet raised
        ST_REQ   = 3'd2,  // IRQ raised, waiting for acknowledge
        ST_ACK   = 3'd3,  // acknowledge in progress, bus driven
        ST_SERVE = 3'd4   // handler running, waiting for service end
    } node_state_e;

endpackage

// File: rtl/ise_rise_detect.sv
`timescale 1ns/1ps
// Module: ise_rise_detect
// Finds the rising edge of the half-cycle active-low service-end pulse.
// Assumes the pulse spans a falling clock edge, so a falling-edge
// sample always catches its low phase. The result is a one-cycle
// strobe in the rising-edge domain, with no clock other than clk.
module ise_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ise_n_in,
    output logic rise
);

    logic ise_fall_q;   // falling-edge sample of the line
    logic ise_rise_q;   // same sample, moved to the rising edge

    // Capture the line mid-cycle so a half-clock pulse is never missed.
    always_ff @(negedge clk) begin
        if (!rst_n) ise_fall_q <= 1'b1;
        else        ise_fall_q <= ise_n_in;
    end

    // Hand the sample over to the rising-edge domain.
    always_ff @(posedge clk) begin
        if (!rst_n) ise_rise_q <= 1'b1;
        else        ise_rise_q <= ise_fall_q;
    end

    // A high sample following a low one marks the end of the pulse.
    assign rise = ise_fall_q & ~ise_rise_q;

endmodule

// File: rtl/downstream_watch.sv
`timescale 1ns/1ps
// Module: downstream_watch
// Records that a node further out owns the CPU. That is true from the
// moment an acknowledge passes through the closed chain until a
// service-end pulse passes through it. Assumes handlers run one at a
// time, so exactly one service-end pulse closes each ownership.
module downstream_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic chain_open,
    input  logic iak_in,
    input  logic ise_rise,
    output logic down_busy
);

    // Set on a forwarded acknowledge, clear on a forwarded service end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      down_busy <= 1'b0;
        else if (!chain_open && iak_in)  down_busy <= 1'b1;
        else if (!chain_open && ise_rise) down_busy <= 1'b0;
    end

endmodule

// File: rtl/node_fsm.sv
`timescale 1ns/1ps
// Module: node_fsm
// Request life cycle of one node: break the chain, raise IRQ, serve the
// acknowledge, then hold the chain open until service ends.
// Assumes iak_in only rises after IRQ has been seen and stays high for
// at least one rising edge.
module node_fsm
    import irq_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dev_req,
    input  logic        iak_in,
    input  logic        down_busy,
    input  logic        ise_rise,
    output node_state_e state,
    output logic        chain_open,
    output logic        own_irq,
    output logic        own_oe
);

    node_state_e state_nx;

    // Next-state choice for each phase of the request.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (dev_req && !iak_in && !down_busy) state_nx = ST_OPEN;
            ST_OPEN:  state_nx = iak_in ? ST_ACK : ST_REQ;
            ST_REQ:   if (iak_in)   state_nx = ST_ACK;
            ST_ACK:   if (!iak_in)  state_nx = ST_SERVE;
            ST_SERVE: if (ise_rise) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Decode of the phase into chain, request and bus controls.
    always_comb begin
        chain_open = (state != ST_IDLE);
        own_irq    = (state == ST_REQ) || (state == ST_ACK);
        own_oe     = iak_in && ((state == ST_OPEN) || (state == ST_REQ) || (state == ST_ACK));
    end

endmodule

// File: rtl/chain_gate.sv
`timescale 1ns/1ps
// Module: chain_gate
// Gating of the three chain lines. When closed, the lines pass straight
// through. When open, the node's own request replaces the far request
// and the acknowledge and service-end lines are held at their
// inactive levels further out.
module chain_gate (
    input  logic chain_open,
    input  logic own_irq,
    input  logic irq_in,
    input  logic iak_in,
    input  logic ise_n_in,
    output logic irq_out,
    output logic iak_out,
    output logic ise_n_out
);

    // Pass or block each line according to the chain state.
    always_comb begin
        irq_out   = chain_open ? own_irq : irq_in;
        iak_out   = chain_open ? 1'b0    : iak_in;
        ise_n_out = chain_open ? 1'b1    : ise_n_in;
    end

endmodule

// File: rtl/irq_chain_node.sv
`timescale 1ns/1ps
// Module: irq_chain_node
// One interrupter node on a daisy chain of IRQ / IAK / ISE lines.
// Assumes the CPU serves one handler at a time, that the service-end
// pulse spans a falling clock edge, and that handler_addr is static.
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_req,
    input  logic [ADDR_W-1:0] handler_addr,
    input  logic              irq_in,
    output logic              irq_out,
    input  logic              iak_in,
    output logic              iak_out,
    input  logic              ise_n_in,
    output logic              ise_n_out,
    output logic [ADDR_W-1:0] bus_data,
    output logic              bus_oe
);

    localparam logic [ADDR_W-1:0] BUS_IDLE = '0;

    node_state_e state;
    logic        chain_open;
    logic        own_irq;
    logic        own_oe;
    logic        down_busy;
    logic        ise_rise;

    ise_rise_detect u_ise (
        .clk      (clk),
        .rst_n    (rst_n),
        .ise_n_in (ise_n_in),
        .rise     (ise_rise)
    );

    downstream_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_open (chain_open),
        .iak_in     (iak_in),
        .ise_rise   (ise_rise),
        .down_busy  (down_busy)
    );

    node_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .iak_in     (iak_in),
        .down_busy  (down_busy),
        .ise_rise   (ise_rise),
        .state      (state),
        .chain_open (chain_open),
        .own_irq    (own_irq),
        .own_oe     (own_oe)
    );

    chain_gate u_gate (
        .chain_open (chain_open),
        .own_irq    (own_irq),
        .irq_in     (irq_in),
        .iak_in     (iak_in),
        .ise_n_in   (ise_n_in),
        .irq_out    (irq_out),
        .iak_out    (iak_out),
        .ise_n_out  (ise_n_out)
    );

    // Bus driver: address only while the acknowledge enables it.
    always_comb begin
        bus_oe   = own_oe;
        bus_data = own_oe ? handler_addr : BUS_IDLE;
    end

endmodule

// File: rtl/irq_chain_node_chk.sv
`timescale 1ns/1ps
// Module: irq_chain_node_chk
// Protocol checks for irq_chain_node, attached by bind below.
module irq_chain_node_chk
    import irq_chain_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iak_in,
    input logic              iak_out,
    input logic              ise_n_out,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] bus_data,
    input node_state_e       state,
    input logic              chain_open,
    input logic              own_irq,
    input logic              down_busy,
    input logic              ise_rise
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !down_busy));

    p_oe_needs_iak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> iak_in);

    p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));

    p_oe_blocks_far_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !iak_out);

    p_open_before_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_irq) |-> $past(chain_open));

    p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && !iak_in) |=> (!own_irq && chain_open));

    p_ise_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE) |-> ise_n_out);

    p_serve_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE && !ise_rise) |=> (state == ST_SERVE));

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && down_busy) |=> (state == ST_IDLE));

endmodule

bind irq_chain_node irq_chain_node_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iak_in     (iak_in),
    .iak_out    (iak_out),
    .ise_n_out  (ise_n_out),
    .bus_oe     (bus_oe),
    .bus_data   (bus_data),
    .state      (state),
    .chain_open (chain_open),
    .own_irq    (own_irq),
    .down_busy  (down_busy),
    .ise_rise   (ise_rise)
);

// File: tb/tb_irq_chain_node.sv
`timescale 1ns/100ps
module tb_irq_chain_node;

    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] DUT_ADDR = 16'hC3A5;
    localparam logic [ADDR_W-1:0] EXP_ORDER [3] = '{16'hA000, 16'hA101, 16'hA202};
    // {irq_in, iak_in, ise_n_in, exp irq_out, exp iak_out, exp ise_n_out}
    localparam logic [5:0] PASS_TBL [7] = '{
        6'b001001, 6'b101101, 6'b011011, 6'b000000,
        6'b111111, 6'b100100, 6'b001001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // standalone node
    logic              dev_req = 1'b0;
    logic              irq_in = 1'b0, iak_in = 1'b0, ise_n_in = 1'b1;
    logic              irq_out, iak_out, ise_n_out, bus_oe;
    logic [ADDR_W-1:0] bus_data;

    irq_chain_node #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .handler_addr(DUT_ADDR),
        .irq_in(irq_in), .irq_out(irq_out), .iak_in(iak_in), .iak_out(iak_out),
        .ise_n_in(ise_n_in), .ise_n_out(ise_n_out), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    // three-node cascade, u_near closest to the CPU
    logic [2:0]        c_req = 3'b000;
    logic              cpu_iak = 1'b0, cpu_ise_n = 1'b1;
    logic              cpu_irq;
    logic              irq_m2n, irq_f2m, iak_n2m, iak_m2f, ise_n2m, ise_m2f;
    logic              iak_far, ise_far;
    logic [2:0]        c_oe;
    logic [ADDR_W-1:0] d_near, d_mid, d_far;
    logic [ADDR_W-1:0] cbus;
    assign cbus = d_near | d_mid | d_far;

    irq_chain_node #(.ADDR_W(ADDR_W)) u_near (
        .clk(clk), .rst_n(rst_n), .dev_req(c_req[0]), .handler_addr(EXP_ORDER[0]),
        .irq_in(irq_m2n), .irq_out(cpu_irq), .iak_in(cpu_iak), .iak_out(iak_n2m),
        .ise_n_in(cpu_ise_n), .ise_n_out(ise_n2m), .bus_data(d_near), .bus_oe(c_oe[0])
    );
    irq_chain_node #(.ADDR_W(ADDR_W)) u_mid (
        .clk(clk), .rst_n(rst_n), .dev_req(c_req[1]), .handler_addr(EXP_ORDER[1]),
        .irq_in(irq_f2m), .irq_out(irq_m2n), .iak_in(iak_n2m), .iak_out(iak_m2f),
        .ise_n_in(ise_n2m), .ise_n_out(ise_m2f), .bus_data(d_mid), .bus_oe(c_oe[1])
    );
    irq_chain_node #(.ADDR_W(ADDR_W)) u_far (
        .clk(clk), .rst_n(rst_n), .dev_req(c_req[2]), .handler_addr(EXP_ORDER[2]),
        .irq_in(1'b0), .irq_out(irq_f2m), .iak_in(iak_m2f), .iak_out(iak_far),
        .ise_n_in(ise_m2f), .ise_n_out(ise_far), .bus_data(d_far), .bus_oe(c_oe[2])
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive point: 2 ns after a rising edge
    task automatic drive_slot;
        @(posedge clk);
        #2;
    endtask

    // half-clock low pulse around the falling edge of one cycle
    task automatic ise_pulse(ref logic line);
        @(posedge clk);
        #2.5 line = 1'b0;
        #5   line = 1'b1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    initial begin
        int got;
        do_reset();
        #6;
        chk("R1", "irq_out after reset", irq_out, 0);
        chk("R1", "bus_oe after reset", bus_oe, 0);
        chk("R1", "bus_data after reset", bus_data, 0);
        chk("R1", "ise_n_out after reset", ise_n_out, 1);
        chk("R1", "cascade irq after reset", cpu_irq, 0);

        // R2: pass-through table with the chain closed
        for (int i = 0; i < 7; i++) begin
            drive_slot();
            {irq_in, iak_in, ise_n_in} = PASS_TBL[i][5:3];
            #6;
            chk("R2", "irq_out pass", irq_out, PASS_TBL[i][2]);
            chk("R2", "iak_out pass", iak_out, PASS_TBL[i][1]);
            chk("R2", "ise_n_out pass", ise_n_out, PASS_TBL[i][0]);
        end
        do_reset();

        // single request with a far request pending
        irq_in = 1'b1;
        drive_slot(); dev_req = 1'b1; #6;
        chk("R2", "closed forwards far irq", irq_out, 1);
        drive_slot(); dev_req = 1'b0; #6;
        chk("R3", "chain open, irq not yet raised", irq_out, 0);
        chk("R8", "local request took chain over pending far irq", irq_out, 0);
        drive_slot(); iak_in = 1'b1; #6;
        chk("R3", "irq raised one cycle after opening", irq_out, 1);
        chk("R3", "iak blocked outward", iak_out, 0);
        chk("R4", "bus_oe with iak", bus_oe, 1);
        chk("R4", "bus_data address", bus_data, DUT_ADDR);
        drive_slot(); iak_in = 1'b0; #6;
        chk("R4", "bus_oe released", bus_oe, 0);
        chk("R4", "bus_data zero", bus_data, 0);
        chk("R5", "irq held until iak low sampled", irq_out, 1);
        drive_slot(); #6;
        chk("R5", "irq dropped, chain still open", irq_out, 0);
        @(posedge clk);
        #2.5 ise_n_in = 1'b0;
        #1.5 chk("R6", "pulse not forwarded", ise_n_out, 1);
        #3.5 ise_n_in = 1'b1;
        @(posedge clk); #8;
        chk("R6", "chain open at first edge after pulse", irq_out, 0);
        @(posedge clk); #8;
        chk("R6", "chain closed at second edge after pulse", irq_out, 1);
        do_reset();

        // downstream ownership blocks local request
        drive_slot(); iak_in = 1'b1; #6;
        chk("R2", "closed forwards iak", iak_out, 1);
        drive_slot(); iak_in = 1'b0; dev_req = 1'b1; irq_in = 1'b1;
        repeat (3) @(posedge clk);
        #8 chk("R7", "request held while far node owns", irq_out, 1);
        @(posedge clk);
        #2.5 ise_n_in = 1'b0;
        #1.5 chk("R2", "closed forwards service end", ise_n_out, 0);
        #3.5 ise_n_in = 1'b1;
        @(posedge clk); #8;
        chk("R7", "still closed first edge", irq_out, 1);
        @(posedge clk); #8;
        chk("R7", "still closed while record clears", irq_out, 1);
        @(posedge clk); #8;
        chk("R7", "chain opens after ownership ends", irq_out, 0);
        dev_req = 1'b0; irq_in = 1'b0;
        do_reset();

        // R9: cascade with simultaneous requests
        drive_slot(); c_req = 3'b111;
        drive_slot(); c_req = 3'b000;
        for (int k = 0; k < 3; k++) begin
            got = 0;
            for (int w = 0; w < 40; w++) begin
                @(posedge clk); #8;
                if (cpu_irq) begin got = 1; break; end
            end
            chk("R9", "irq reaches cpu", got, 1);
            drive_slot(); cpu_iak = 1'b1; #6;
            chk("R9", "single bus driver", $countones(c_oe), 1);
            chk("R9", "handler order", cbus, EXP_ORDER[k]);
            drive_slot(); cpu_iak = 1'b0;
            @(posedge clk);
            ise_pulse(cpu_ise_n);
        end
        repeat (4) @(posedge clk);
        #8 chk("R9", "irq idle after last handler", cpu_irq, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule